// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a byte-wide non-volatile memory. The page write controller hands it a one-cycle start pulse together with the top bit of the last byte it loaded. The reporter then runs a self-timed program-cycle timer. While that timer runs, the block replaces the read data with progress status: the top data bit returns the inverse of the saved bit, and the next bit down flips once for every completed read. When the timer expires, reads return the plain array data again.

The same block owns the write-allow decision. Writes stay blocked for a fixed interval after reset, which stands for the power-up settling delay. They are also blocked while a supply-sense input reports low voltage, and while a program cycle is running. A start pulse that arrives while writes are blocked is dropped.

The array read is represented by a plain data input, and the output enable stands in for the bus driver. Tristate timing is not modelled.

Top module: `prog_status_top`

## Requirements
- R1: While reset is asserted, `busy` and `write_allow` are 0.
- R2: After reset is released, `write_allow` stays 0 for the first INIT_TICKS rising clock edges. It becomes 1 after edge number INIT_TICKS, provided `supply_low` is 0 and no cycle is running.
- R3: In any cycle where `supply_low` is 1, `write_allow` is 0 in that same cycle.
- R4: A `prog_start` sampled on a clock edge while `write_allow` is 1 makes `busy` 1 after that edge, and `prog_msb` is saved at that edge. A `prog_start` sampled while `write_allow` is 0 has no effect: it does not raise `busy`, and it does not change the saved bit.
- R5: `busy` stays 1 for exactly CYCLE_TICKS clock cycles and then returns to 0. `write_allow` is 0 in every cycle where `busy` is 1.
- R6: During a read while `busy` is 1, the top data bit (bit DATA_W-1, bit 7 by default) is the inverse of the saved `prog_msb`.
- R7: During a read while `busy` is 1, bit DATA_W-2 (bit 6) carries a toggle flag. The flag is 0 on the first read after a cycle starts. It inverts once at the end of each read made while busy, where a read ends in the cycle after the read condition drops.
- R8: During a read while `busy` is 0, `data_out` equals `array_data` on every bit.
- R9: A read is `we_n`=1 with both `ce_n`=0 and `oe_n`=0. When that condition is false, `data_oe` is 0 and `data_out` is all zeros.
- R10: While one read is held over several cycles during busy, the toggle bit does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | One-cycle request from the page write controller to begin a program cycle |
| prog_msb | input | 1 | Top bit of the last byte loaded; saved when a start is accepted |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| array_data | input | DATA_W | Stored data for the addressed location |
| supply_low | input | 1 | Supply sense; 1 when the supply is under threshold |
| data_out | output | DATA_W | Read data or status; zero when no read is active |
| data_oe | output | 1 | High while a read drives the bus |
| busy | output | 1 | Program cycle in progress |
| write_allow | output | 1 | New write may be accepted |

## Verification
The checker enforces these rules on every cycle:
- `write_allow` is gated by supply, by busy and by the power-up window.
- An accepted start raises busy, and a start made while writes are blocked leaves busy at 0.
- The busy period lasts exactly CYCLE_TICKS cycles, counted by the checker's own counter.
- The polled top bit is the inverse of the saved bit, true data is returned when idle, and the bus is released outside a read.

The bench scenarios are what show the toggle sequence across separate reads, its restart at 0 on each new cycle, and its hold during a long read. They also show that a start dropped during busy does not disturb the saved polling bit.

// File: rtl/prog_status_pkg.sv
package prog_status_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } bus_src_t;

  typedef struct packed {
    logic active;
    logic ended;
  } rd_evt_t;

  function automatic bus_src_t pick_src(input logic rd, input logic in_cycle);
    if (!rd)
      return SRC_NONE;
    else if (in_cycle)
      return SRC_STATUS;
    else
      return SRC_ARRAY;
  endfunction

  function automatic logic gate_write(input logic settled, input logic low_supply,
                                      input logic in_cycle);
    return settled & ~low_supply & ~in_cycle;
  endfunction

endpackage

// File: rtl/prog_cycle_timer.sv
module prog_cycle_timer #(
  parameter int unsigned TICKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic cycle_end
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  assign cycle_end = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cycle_end) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= bump(cnt);
      end
    end
  end

endmodule

// File: rtl/power_up_guard.sv
module power_up_guard #(
  parameter int unsigned INIT_TICKS = 7500
) (
  input  logic clk,
  input  logic rst_n,
  output logic settled
);
  localparam int unsigned CW = $clog2(INIT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      settled <= 1'b0;
    end else if (!settled) begin
      if (cnt == LAST)
        settled <= 1'b1;
      else
        cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/read_tracker.sv
module read_tracker
  import prog_status_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    in_cycle,
  input  logic    restart,
  output rd_evt_t evt,
  output logic    flip_bit
);
  logic rd_now;
  logic rd_q;

  assign rd_now     = ~ce_n & ~oe_n & we_n;
  assign evt.active = rd_now;
  assign evt.ended  = rd_q & ~rd_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      flip_bit <= 1'b0;
    end else begin
      rd_q <= rd_now;
      if (restart)
        flip_bit <= 1'b0;
      else if (in_cycle && evt.ended)
        flip_bit <= ~flip_bit;
    end
  end

endmodule

// File: rtl/prog_status_top.sv
module prog_status_top
  import prog_status_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CYCLE_TICKS = 5000,
  parameter int unsigned INIT_TICKS  = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              prog_msb,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] array_data,
  input  logic              supply_low,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              busy,
  output logic              write_allow
);
  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned FLIP_BIT = DATA_W - 2;

  logic     settled;
  logic     accept;
  logic     cycle_end;
  logic     saved_msb;
  logic     flip_q;
  rd_evt_t  rd_evt;
  bus_src_t src;

  function automatic logic [DATA_W-1:0] status_word(input logic msb, input logic flip,
                                                    input logic [DATA_W-1:0] raw);
    logic [DATA_W-1:0] w;
    w           = raw;
    w[POLL_BIT] = ~msb;
    w[FLIP_BIT] = flip;
    return w;
  endfunction

  assign write_allow = gate_write(settled, supply_low, busy);
  assign accept      = prog_start & write_allow;

  power_up_guard #(.INIT_TICKS(INIT_TICKS)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .settled (settled)
  );

  prog_cycle_timer #(.TICKS(CYCLE_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .busy      (busy),
    .cycle_end (cycle_end)
  );

  read_tracker u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .in_cycle (busy),
    .restart  (accept),
    .evt      (rd_evt),
    .flip_bit (flip_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      saved_msb <= 1'b0;
    else if (accept)
      saved_msb <= prog_msb;
  end

  assign src     = pick_src(rd_evt.active, busy);
  assign data_oe = rd_evt.active;

  always_comb begin
    unique case (src)
      SRC_ARRAY:  data_out = array_data;
      SRC_STATUS: data_out = status_word(saved_msb, flip_q, array_data);
      default:    data_out = '0;
    endcase
  end

endmodule

// File: rtl/prog_status_checker.sv
module prog_status_checker #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CYCLE_TICKS = 5000,
  parameter int unsigned INIT_TICKS  = 7500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_start,
  input logic              prog_msb,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] array_data,
  input logic              supply_low,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              busy,
  input logic              write_allow,
  input logic              cycle_end
);
  logic        rd;
  logic        took;
  logic        msb_ref;
  int unsigned busy_len;
  int unsigned since_rst;

  assign rd   = !ce_n && !oe_n && we_n;
  assign took = prog_start && write_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_ref   <= 1'b0;
      busy_len  <= 0;
      since_rst <= 0;
    end else begin
      if (took)
        msb_ref <= prog_msb;
      busy_len <= busy ? busy_len + 1 : 0;
      if (since_rst < INIT_TICKS)
        since_rst <= since_rst + 1;
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (!busy && !write_allow));

  p_init_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < INIT_TICKS) |-> !write_allow);

  p_supply_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !write_allow);

  p_start_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> busy);

  p_start_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start && !write_allow && !busy) |=> !busy);

  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !write_allow);

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < CYCLE_TICKS));

  p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == CYCLE_TICKS));

  p_end_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !busy);

  p_poll_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd) |-> (data_out[DATA_W-1] == !msb_ref));

  p_true_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd) |-> (data_out == array_data));

  p_bus_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (!data_oe && data_out == '0));

  p_flip_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && rd && $past(rd)) |-> $stable(data_out[DATA_W-2]));

endmodule

bind prog_status_top prog_status_checker #(
  .DATA_W      (DATA_W),
  .CYCLE_TICKS (CYCLE_TICKS),
  .INIT_TICKS  (INIT_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_start  (prog_start),
  .prog_msb    (prog_msb),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .array_data  (array_data),
  .supply_low  (supply_low),
  .data_out    (data_out),
  .data_oe     (data_oe),
  .busy        (busy),
  .write_allow (write_allow),
  .cycle_end   (cycle_end)
);

// File: tb/sim_prog_status_top.sv
`timescale 1ns/1ps
module sim_prog_status_top;
  localparam int unsigned DW    = 8;
  localparam int unsigned CYC_T = 40;
  localparam int unsigned INI_T = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_start;
  logic          prog_msb;
  logic          ce_n;
  logic          oe_n;
  logic          we_n;
  logic [DW-1:0] array_data;
  logic          supply_low;
  logic [DW-1:0] data_out;
  logic          data_oe;
  logic          busy;
  logic          write_allow;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prog_status_top #(.DATA_W(DW), .CYCLE_TICKS(CYC_T), .INIT_TICKS(INI_T)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_msb(prog_msb),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .array_data(array_data),
    .supply_low(supply_low), .data_out(data_out), .data_oe(data_oe),
    .busy(busy), .write_allow(write_allow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_bus();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy in reset", {31'd0, busy}, 0);
    check("R1 write_allow in reset", {31'd0, write_allow}, 0);
  endtask

  task automatic t_init();
    for (int k = 1; k <= INI_T + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1)         check("R2 blocked just after reset", {31'd0, write_allow}, 0);
      if (k == INI_T - 1) check("R2 blocked one edge early", {31'd0, write_allow}, 0);
      if (k == INI_T)     check("R2 allowed at window end", {31'd0, write_allow}, 1);
    end
  endtask

  task automatic t_supply();
    step(); supply_low = 1'b1;
    @(negedge clk);
    check("R3 supply low blocks", {31'd0, write_allow}, 0);
    step(); prog_start = 1'b1; prog_msb = 1'b1;
    step(); prog_start = 1'b0;
    @(negedge clk);
    check("R4 start ignored while blocked", {31'd0, busy}, 0);
    step(); supply_low = 1'b0;
    @(negedge clk);
    check("R3 supply restored", {31'd0, write_allow}, 1);
  endtask

  task automatic t_read_idle();
    step(); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; array_data = 8'h5A;
    @(negedge clk);
    check("R8 idle read data", {24'd0, data_out}, 32'h5A);
    check("R9 oe during read", {31'd0, data_oe}, 1);
    step(); array_data = 8'hA5;
    @(negedge clk);
    check("R8 idle read data 2", {24'd0, data_out}, 32'hA5);
    step(); oe_n = 1'b1;
    @(negedge clk);
    check("R9 oe_n high releases", {23'd0, data_oe, data_out}, 0);
    step(); oe_n = 1'b0; ce_n = 1'b1;
    @(negedge clk);
    check("R9 ce_n high releases", {23'd0, data_oe, data_out}, 0);
    step(); ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    check("R9 write strobe is no read", {23'd0, data_oe, data_out}, 0);
    step(); idle_bus();
  endtask

  task automatic t_prog(input logic b7);
    int  acc;
    logic exp_t;
    step(); prog_start = 1'b1; prog_msb = b7;
    step(); prog_start = 1'b0;
    acc = cyc;
    @(negedge clk);
    check("R4 busy after accepted start", {31'd0, busy}, 1);
    check("R5 write blocked while busy", {31'd0, write_allow}, 0);
    step(); prog_start = 1'b1; prog_msb = ~b7;
    step(); prog_start = 1'b0;
    exp_t = 1'b0;
    for (int r = 0; r < 3; r++) begin
      step(); ce_n = 1'b0; oe_n = 1'b0; array_data = 8'h3C ^ 8'(r);
      @(negedge clk);
      check("R6 poll bit inverted", {31'd0, data_out[7]}, {31'd0, ~b7});
      check("R7 toggle bit", {31'd0, data_out[6]}, {31'd0, exp_t});
      step();
      @(negedge clk);
      check("R10 toggle held in long read", {31'd0, data_out[6]}, {31'd0, exp_t});
      step(); idle_bus();
      exp_t = ~exp_t;
    end
    while (cyc < acc + int'(CYC_T) - 1) step();
    @(negedge clk);
    check("R5 busy on last cycle", {31'd0, busy}, 1);
    step();
    @(negedge clk);
    check("R5 busy cleared after window", {31'd0, busy}, 0);
    check("R5 write allowed again", {31'd0, write_allow}, 1);
    step(); ce_n = 1'b0; oe_n = 1'b0; array_data = {b7, 7'h15};
    @(negedge clk);
    check("R8 true data after cycle", {24'd0, data_out}, {24'd0, b7, 7'h15});
    step(); idle_bus();
  endtask

  initial begin
    rst_n = 1'b1; prog_start = 1'b0; prog_msb = 1'b0; array_data = '0;
    supply_low = 1'b0; idle_bus();
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    step(); rst_n = 1'b1;
    t_init();
    t_supply();
    t_read_idle();
    t_prog(1'b1);
    t_prog(1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule